// File: doc/BRIEF.md
# Banked GPIO Interrupt Aggregator

The block watches a wide set of general-purpose input pins. Every sixteen consecutive pins form a bank. Each pin is first passed through a two-flop synchroniser. It then goes through an edge detector, which can respond to a rising edge, a falling edge or both. A detected event sets a sticky pending bit for that pin. Software clears a pending bit by writing 1 to it.

Each pending bit is driven out as its own level line interrupt. The pending bits of a bank are also ORed together and gated by that bank's enable bit, which gives one level interrupt per bank. Software that receives a bank interrupt reads the packed status words to find the pin that caused it.

Only the lowest `USED_PINS` pins are treated as present. Higher pins are always inactive. A bank that contains none of the present pins is also inactive.

Configuration and status go through a small synchronous register port. A word address is decoded as follows:

- Address 0x00 holds the bank enables.
- Addresses 0x08 and up hold the status words.
- Addresses 0x10 and up hold the rising-edge enables.
- Addresses 0x18 and up hold the falling-edge enables.

Word `w` of each per-pin group covers pins 32w to 32w+31. Pin `p` sits at bit `p mod 32`. The low half of a word therefore holds bank 2w and the high half holds bank 2w+1.

Top module: `gpio_bank_irq_agg`

## Requirements
- R1: Pin p belongs to bank p/16, and bank_irq_o[k] responds only to pending pins 16k..16k+15.
- R2: The status word at address 0x08+w reads pin 32w+i at bit i, so a pending pin 18 reads 0x00040000 at address 0x08.
- R3: Bank enable register at address 0x00 has bit k for bank k, and bank_irq_o[k] is 0 whenever that bit is 0.
- R4: bank_irq_o[k] is a level output. It is 1 exactly while bank k is enabled and at least one of its pins is pending, and it drops when the last pending bit is cleared.
- R5: The rising-edge enables at 0x10+w and the falling-edge enables at 0x18+w use the same bit packing as status. Only the enabled edge kinds set the pending bit, and setting both enables makes either edge count.
- R6: A pending bit stays 1 until cleared, and line_irq_o[p] equals pin p's pending bit.
- R7: Writing 1 to a status bit clears it. Writing 0 to a status bit leaves it unchanged.
- R8: If an event and a clear of the same pin fall in the same cycle, the bit stays 1.
- R9: Pins at or above USED_PINS never become pending. Their edge-enable bits read 0, and enable bits of banks with no present pin read 0.
- R10: Read data appears on rdata_o one clock after the address. Unmapped addresses, including status or edge words beyond the last bank pair, read 0.
- R11: A pin change applied before clock edge n sets the pending bit at edge n+2, not earlier.
- R12: After reset every register, every pending bit and every interrupt output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pins_i | input | N_BANKS*16 | Asynchronous GPIO pin levels |
| addr_i | input | 5 | Register word address |
| we_i | input | 1 | Write enable |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered from addr_i |
| line_irq_o | output | N_BANKS*16 | Per-pin level interrupt (pending bit) |
| bank_irq_o | output | N_BANKS | Per-bank level interrupt |

## Verification
Suppose a pending bit is lost or set when it should not be. That error shows on the matching line_irq_o bit in the cycle after the faulty edge. It shows on bank_irq_o in the same cycle, provided the bank is enabled. A wrong edge-enable or bank-enable register shows in the read-back one cycle after its address is presented. The same wrong register shows on the interrupt outputs three cycles after the next pin change. A slip in the synchroniser depth shows as pending bits rising one edge early or late against the fixed three-edge latency.

// File: rtl/gpio_agg_pkg.sv
package gpio_agg_pkg;
  localparam int unsigned PINS_PER_BANK = 16;
  localparam int unsigned WORD_W        = 32;
  localparam int unsigned ADDR_W        = 5;

  localparam logic [1:0] GRP_CTRL = 2'd0;
  localparam logic [1:0] GRP_STAT = 2'd1;
  localparam logic [1:0] GRP_RISE = 2'd2;
  localparam logic [1:0] GRP_FALL = 2'd3;

  typedef enum logic [2:0] {
    REG_NONE,
    REG_EN,
    REG_STAT,
    REG_RISE,
    REG_FALL
  } reg_sel_e;

  typedef struct packed {
    reg_sel_e   sel;
    logic [2:0] idx;
  } reg_dec_t;

  function automatic reg_dec_t decode_addr(input logic [ADDR_W-1:0] addr,
                                           input int unsigned n_words);
    reg_dec_t d;
    logic     in_range;
    d.idx    = addr[2:0];
    d.sel    = REG_NONE;
    in_range = (32'(addr[2:0]) < n_words);
    case (addr[4:3])
      GRP_CTRL: if (addr[2:0] == 3'd0) d.sel = REG_EN;
      GRP_STAT: if (in_range) d.sel = REG_STAT;
      GRP_RISE: if (in_range) d.sel = REG_RISE;
      GRP_FALL: if (in_range) d.sel = REG_FALL;
      default:  d.sel = REG_NONE;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;
endmodule

// File: rtl/gpio_pin_evt.sv
module gpio_pin_evt (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  input  logic rise_en_i,
  input  logic fall_en_i,
  input  logic clr_i,
  output logic stat_o
);
  logic prev_q, stat_q, evt;

  assign evt = (rise_en_i & sync_i & ~prev_q) | (fall_en_i & ~sync_i & prev_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      prev_q <= sync_i;
      stat_q <= evt | (stat_q & ~clr_i);  // set beats clear
    end
  end

  assign stat_o = stat_q;

  assert_evt_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt |=> stat_q);
  assert_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q && !clr_i) |=> stat_q);
  assert_w1c_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !evt) |=> !stat_q);
  assert_set_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_q) |-> $past(rise_en_i || fall_en_i));
endmodule

// File: rtl/gpio_bank_agg.sv
module gpio_bank_agg #(
  parameter int unsigned N_BANKS    = 9,
  parameter int unsigned USED_BANKS = 9,
  parameter int unsigned BANK_W     = 16
) (
  input  logic [N_BANKS*BANK_W-1:0] stat_i,
  input  logic [N_BANKS-1:0]        en_i,
  output logic [N_BANKS-1:0]        irq_o
);
  for (genvar k = 0; k < N_BANKS; k++) begin : g_bank
    if (k < USED_BANKS) begin : g_act
      assign irq_o[k] = en_i[k] & (|stat_i[k*BANK_W +: BANK_W]);
    end else begin : g_off
      logic unused_bank;
      assign unused_bank = en_i[k] ^ (|stat_i[k*BANK_W +: BANK_W]);
      assign irq_o[k]    = 1'b0;
    end
  end
endmodule

// File: rtl/gpio_bank_irq_agg.sv
module gpio_bank_irq_agg
  import gpio_agg_pkg::*;
#(
  parameter int unsigned N_BANKS   = 9,
  parameter int unsigned USED_PINS = 84
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [N_BANKS*PINS_PER_BANK-1:0] pins_i,
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic                            we_i,
  input  logic [WORD_W-1:0]               wdata_i,
  output logic [WORD_W-1:0]               rdata_o,
  output logic [N_BANKS*PINS_PER_BANK-1:0] line_irq_o,
  output logic [N_BANKS-1:0]              bank_irq_o
);
  localparam int unsigned TOTAL_PINS = N_BANKS * PINS_PER_BANK;
  localparam int unsigned N_WORDS    = (N_BANKS + 1) / 2;
  localparam int unsigned REG_PINS   = N_WORDS * WORD_W;
  localparam int unsigned USED_BANKS = (USED_PINS + PINS_PER_BANK - 1) / PINS_PER_BANK;
  localparam logic [REG_PINS-1:0] PIN_MASK  = {REG_PINS{1'b1}} >> (REG_PINS - USED_PINS);
  localparam logic [WORD_W-1:0]   BANK_MASK = {WORD_W{1'b1}} >> (WORD_W - USED_BANKS);

  reg_dec_t              dec;
  logic [N_BANKS-1:0]    en_q;
  logic [REG_PINS-1:0]   rise_q, fall_q, clr_vec, stat;
  logic [USED_PINS-1:0]  sync;
  logic [WORD_W-1:0]     rd_word, rdata_q;

  assign dec = decode_addr(addr_i, N_WORDS);

  // configuration registers; bits of absent pins/banks never store 1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      rise_q <= '0;
      fall_q <= '0;
    end else if (we_i) begin
      if (dec.sel == REG_EN) en_q <= wdata_i[N_BANKS-1:0] & BANK_MASK[N_BANKS-1:0];
      for (int w = 0; w < N_WORDS; w++) begin
        if (int'(dec.idx) == w) begin
          if (dec.sel == REG_RISE)
            rise_q[w*WORD_W +: WORD_W] <= wdata_i & PIN_MASK[w*WORD_W +: WORD_W];
          if (dec.sel == REG_FALL)
            fall_q[w*WORD_W +: WORD_W] <= wdata_i & PIN_MASK[w*WORD_W +: WORD_W];
        end
      end
    end
  end

  always_comb begin
    clr_vec = '0;
    if (we_i && dec.sel == REG_STAT) begin
      for (int w = 0; w < N_WORDS; w++)
        if (int'(dec.idx) == w) clr_vec[w*WORD_W +: WORD_W] = wdata_i;
    end
  end

  gpio_sync #(.W(USED_PINS)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(pins_i[USED_PINS-1:0]),
    .sync_o (sync)
  );

  if (USED_PINS < TOTAL_PINS) begin : g_absent
    logic unused_pins;
    assign unused_pins = ^pins_i[TOTAL_PINS-1:USED_PINS];
  end

  for (genvar p = 0; p < REG_PINS; p++) begin : g_pin
    if (p < USED_PINS) begin : g_on
      gpio_pin_evt u_evt (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .sync_i   (sync[p]),
        .rise_en_i(rise_q[p]),
        .fall_en_i(fall_q[p]),
        .clr_i    (clr_vec[p]),
        .stat_o   (stat[p])
      );
    end else begin : g_off
      logic unused_clr;
      assign unused_clr = clr_vec[p];
      assign stat[p]    = 1'b0;
    end
  end

  assign line_irq_o = stat[TOTAL_PINS-1:0];

  gpio_bank_agg #(
    .N_BANKS   (N_BANKS),
    .USED_BANKS(USED_BANKS),
    .BANK_W    (PINS_PER_BANK)
  ) u_bank (
    .stat_i(stat[TOTAL_PINS-1:0]),
    .en_i  (en_q),
    .irq_o (bank_irq_o)
  );

  always_comb begin
    rd_word = '0;
    case (dec.sel)
      REG_EN: rd_word[N_BANKS-1:0] = en_q;
      REG_STAT, REG_RISE, REG_FALL: begin
        for (int w = 0; w < N_WORDS; w++) begin
          if (int'(dec.idx) == w) begin
            if (dec.sel == REG_STAT) rd_word = stat[w*WORD_W +: WORD_W];
            if (dec.sel == REG_RISE) rd_word = rise_q[w*WORD_W +: WORD_W];
            if (dec.sel == REG_FALL) rd_word = fall_q[w*WORD_W +: WORD_W];
          end
        end
      end
      default: rd_word = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rd_word;
  end

  assign rdata_o = rdata_q;

  assert_unmapped_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec.sel == REG_NONE) |=> (rdata_o == '0));

  for (genvar k = 0; k < N_BANKS; k++) begin : g_chk
    assert_bank_enable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_q[k] |-> !bank_irq_o[k]);
    assert_bank_pending_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bank_irq_o[k] |-> (|line_irq_o[k*PINS_PER_BANK +: PINS_PER_BANK]));
  end
endmodule

// File: tb/test_gpio_bank_irq_agg.sv
`timescale 1ns/1ps
module test_gpio_bank_irq_agg;
  localparam int NB = 9;
  localparam int NP = NB * 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NP-1:0] pins_i = '0;
  logic [4:0]    addr_i = '0;
  logic          we_i = 1'b0;
  logic [31:0]   wdata_i = '0;
  logic [31:0]   rdata_o;
  logic [NP-1:0] line_irq_o;
  logic [NB-1:0] bank_irq_o;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [4:0]  addr;
    logic [31:0] exp;
    string       req;
  } exp_t;
  exp_t exp_q[$];
  logic rd_issue = 1'b0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  gpio_bank_irq_agg #(.N_BANKS(NB), .USED_PINS(84)) i_gpio_bank_irq_agg (
    .clk_i, .rst_ni, .pins_i, .addr_i, .we_i, .wdata_i,
    .rdata_o, .line_irq_o, .bank_irq_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] e, input string req);
    exp_t it;
    @(negedge clk_i);
    addr_i = a;
    it.addr = a; it.exp = e; it.req = req;
    exp_q.push_back(it);
    rd_issue = 1'b1;
    @(negedge clk_i);
    rd_issue = 1'b0;
  endtask

  task automatic drive_pin(input int p, input logic v);
    @(negedge clk_i);
    pins_i[p] = v;
    repeat (3) @(negedge clk_i);
  endtask

  // monitor: compares each registered read with the queued expectation
  always @(posedge clk_i) begin
    if (rd_issue) begin
      exp_t it;
      #5;
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R10: read with empty queue got %h expected none", rdata_o);
      end else begin
        it = exp_q.pop_front();
        chk(it.req, rdata_o, it.exp);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R12 reset state
    chk("R12 line", 32'(|line_irq_o), 32'd0);
    chk("R12 bank", 32'(bank_irq_o), 32'd0);
    rd(5'h00, 32'h0, "R12 en");
    rd(5'h08, 32'h0, "R12 stat0");
    rd(5'h10, 32'h0, "R12 rise0");

    // R5/R11/R2/R6: rising edge on pin 18
    wr(5'h10, 32'h0004_0000);
    rd(5'h10, 32'h0004_0000, "R5 rise readback");
    @(negedge clk_i); pins_i[18] = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i);
    chk("R11 early", 32'(line_irq_o[18]), 32'd0);
    @(negedge clk_i);
    chk("R11 latency", 32'(line_irq_o[18]), 32'd1);
    chk("R3 disabled bank", 32'(bank_irq_o), 32'd0);
    rd(5'h08, 32'h0004_0000, "R2 packing");

    // R1/R4 bank mapping
    wr(5'h00, 32'h002);
    chk("R1 bank of pin18", 32'(bank_irq_o), 32'h002);
    wr(5'h00, 32'h1FF);
    rd(5'h00, 32'h03F, "R9 absent bank enable");
    chk("R1 bank unchanged", 32'(bank_irq_o), 32'h002);

    // R7 writing zero has no effect
    wr(5'h08, 32'hFFFB_FFFF);
    rd(5'h08, 32'h0004_0000, "R7 write zero");

    // R5 falling-only on pin 40
    wr(5'h19, 32'h0000_0100);
    drive_pin(40, 1'b1);
    chk("R5 rise ignored", 32'(line_irq_o[40]), 32'd0);
    drive_pin(40, 1'b0);
    chk("R5 fall", 32'(line_irq_o[40]), 32'd1);
    rd(5'h09, 32'h0000_0100, "R2 word1");
    chk("R4 two banks", 32'(bank_irq_o), 32'h006);

    // R5 both edges on pin 70
    wr(5'h12, 32'h40);
    wr(5'h1A, 32'h40);
    drive_pin(70, 1'b1);
    rd(5'h0A, 32'h40, "R5 both rise");
    wr(5'h0A, 32'h40);
    chk("R7 clear", 32'(line_irq_o[70]), 32'd0);
    drive_pin(70, 1'b0);
    chk("R5 both fall", 32'(line_irq_o[70]), 32'd1);
    chk("R4 three banks", 32'(bank_irq_o), 32'h016);

    // R6 unconfigured pin
    drive_pin(5, 1'b1);
    drive_pin(5, 1'b0);
    chk("R6 unconfigured", 32'(line_irq_o[5]), 32'd0);

    // R8 event wins over simultaneous clear on pin 18
    drive_pin(18, 1'b0);
    chk("R6 held", 32'(line_irq_o[18]), 32'd1);
    @(negedge clk_i); pins_i[18] = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i);
    addr_i = 5'h08; wdata_i = 32'h0004_0000; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
    chk("R8 event wins", 32'(line_irq_o[18]), 32'd1);
    wr(5'h08, 32'h0004_0000);
    chk("R7 clear 18", 32'(line_irq_o[18]), 32'd0);
    chk("R4 drops bank1", 32'(bank_irq_o), 32'h014);

    // R9 absent pins
    wr(5'h12, 32'hFFFF_FFFF);
    rd(5'h12, 32'h000F_FFFF, "R9 rise mask");
    wr(5'h13, 32'hFFFF_FFFF);
    wr(5'h1B, 32'hFFFF_FFFF);
    rd(5'h13, 32'h0, "R9 rise word3");
    rd(5'h1B, 32'h0, "R9 fall word3");
    @(negedge clk_i); pins_i[90] = 1'b1; pins_i[100] = 1'b1;
    repeat (4) @(negedge clk_i);
    chk("R9 pin 90", 32'(line_irq_o[90]), 32'd0);
    chk("R9 pin 100", 32'(line_irq_o[100]), 32'd0);
    chk("R9 bank6", 32'(bank_irq_o[6]), 32'd0);

    // R10 unmapped
    rd(5'h07, 32'h0, "R10 hole");
    rd(5'h0D, 32'h0, "R10 stat beyond");
    rd(5'h01, 32'h0, "R10 ctrl hole");

    // R4 level and R3 masking
    repeat (5) @(negedge clk_i);
    chk("R4 level held", 32'(bank_irq_o), 32'h014);
    wr(5'h00, 32'h02F);
    chk("R3 bank4 masked", 32'(bank_irq_o), 32'h004);
    chk("R3 line kept", 32'(line_irq_o[70]), 32'd1);

    repeat (3) @(negedge clk_i);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R10: got %0d pending reads expected 0", exp_q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule